// File: doc/BRIEF.md
# Serial Clock Stop Controller

This block lets software stop and restart individual clock outputs of a clock distribution tree through a two-wire serial port. A frame on the serial data line opens with a single low start bit. Twelve enable bits follow, one per serial clock period, and each is sampled on the rising edge of a free-running serial clock. When the last bit arrives, the whole word moves at once from a shadow register into the active enable register.

Fourteen ungated clocks enter the block. Twelve of them are gated by their own enable bit, and the other two always pass through. Each active enable bit is brought into the domain of its target clock by two flops. It is then captured on that clock's falling edge and combined with the clock. A stopped output therefore rests low, and every high pulse that does reach an output keeps its full width.

Top module: `clkstop_top`

## Requirements
- R1: After reset every enable bit is 1, so all 14 outputs `clkOut` follow `clkIn`.
- R2: While idle, the receiver starts a frame only when it samples 0 on `serData` at a rising `serClk` edge. Ones sampled while idle change nothing.
- R3: The k-th bit after the start bit (k = 0 first) controls `clkIn[k]`. Indices 0-3 are bank A outputs 0-3, 4-7 are bank B outputs 0-3, 8-10 are bank C outputs 1-3, and 11 is the sync output.
- R4: The active enables change only at the rising `serClk` edge that samples the 12th data bit. A frame that is still incomplete leaves the outputs unchanged.
- R5: An enable bit of 1 lets its output run. An enable bit of 0 holds the output at logic low.
- R6: An enable takes effect only while its clock is low, so every high pulse on an output equals the high phase of its input clock.
- R7: `clkIn[12]` (bank C output 0) and `clkIn[13]` (feedback) pass to `clkOut` whatever the enable word holds.
- R8: The receiver is idle again right after the 12th bit, so a start bit in the very next serial period begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| serClk | input | 1 | Free-running serial clock; data is sampled on its rising edge |
| serData | input | 1 | Serial frame: low start bit, then 12 enable bits |
| rstN | input | 1 | Asynchronous active-low reset |
| clkIn | input | 14 | Ungated clocks; indices 0-11 gateable, 12 and 13 always pass |
| clkOut | output | 14 | Gated clocks |

## Verification
Four properties are checked on every cycle. A gate's enable is never updated while its clock is high. The active word moves only on a load strobe. The receiver drops back to idle after the load. Ones on an idle line never start a frame. The bench scenarios are needed for everything else: the bit-to-output mapping, the pass-through of the two ungated clocks, a frame that stalls before completion, back-to-back frames, and pulse widths measured on every output while the enables are flipped rapidly.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } loadStrobes_t;
endpackage

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int NBITS = 12
) (
  input  logic         serClk,
  input  logic         rstN,
  input  logic         serData,
  output loadStrobes_t strobes
);
  localparam int CW = $clog2(NBITS);
  localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

  logic          busy;
  logic [CW-1:0] bitCnt;

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitCnt <= '0;
    end else if (!busy) begin
      if (!serData) begin
        busy   <= 1'b1;
        bitCnt <= '0;
      end
    end else if (bitCnt == LAST) begin
      busy   <= 1'b0;
      bitCnt <= '0;
    end else begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.shiftEn = busy;
    strobes.loadEn  = busy && (bitCnt == LAST);
  end

  AST_IDLE_AFTER_LOAD: assert property (@(posedge serClk) disable iff (!rstN)
    strobes.loadEn |=> !busy); // R8
  AST_WAIT_FOR_START: assert property (@(posedge serClk) disable iff (!rstN)
    (!busy && serData) |=> !strobes.shiftEn); // R2
endmodule

// File: rtl/clkstop_regs.sv
`timescale 1ns/1ps
module clkstop_regs
  import clkstop_pkg::*;
#(
  parameter int NBITS = 12
) (
  input  logic             serClk,
  input  logic             rstN,
  input  logic             serData,
  input  loadStrobes_t     strobes,
  output logic [NBITS-1:0] activeEn
);
  logic [NBITS-1:0] shadow;
  logic [NBITS-1:0] nextWord;

  always_comb nextWord = {serData, shadow[NBITS-1:1]};

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      shadow   <= '1;
      activeEn <= '1;
    end else begin
      if (strobes.shiftEn) shadow <= nextWord;
      if (strobes.loadEn) activeEn <= nextWord;
    end
  end

  AST_ACTIVE_ONLY_ON_LOAD: assert property (@(posedge serClk) disable iff (!rstN)
    !strobes.loadEn |=> $stable(activeEn)); // R4
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate (
  input  logic clk,
  input  logic rstN,
  input  logic enAsync,
  output logic clkOut
);
  logic syncA, syncB, enLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= enAsync;
      syncB <= syncA;
    end
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) enLow <= 1'b1;
    else       enLow <= syncB;
  end

  assign clkOut = clk & enLow;

  logic enAtRise;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enAtRise <= 1'b1;
    else       enAtRise <= enLow;
  end

  AST_ENABLE_LOW_PHASE: assert property (@(negedge clk) disable iff (!rstN)
    enAtRise == enLow); // R6
endmodule

// File: rtl/clkstop_top.sv
`timescale 1ns/1ps
module clkstop_top
  import clkstop_pkg::*;
#(
  parameter int NGATE = 12,
  parameter int NPASS = 2
) (
  input  logic                   serClk,
  input  logic                   serData,
  input  logic                   rstN,
  input  logic [NGATE+NPASS-1:0] clkIn,
  output logic [NGATE+NPASS-1:0] clkOut
);
  loadStrobes_t     strobes;
  logic [NGATE-1:0] activeEn;

  clkstop_ctrl #(.NBITS(NGATE)) i_ctrl (
    .serClk(serClk), .rstN(rstN), .serData(serData), .strobes(strobes)
  );

  clkstop_regs #(.NBITS(NGATE)) i_regs (
    .serClk(serClk), .rstN(rstN), .serData(serData),
    .strobes(strobes), .activeEn(activeEn)
  );

  for (genvar g = 0; g < NGATE; g++) begin : gGate
    clkstop_gate i_gate (
      .clk(clkIn[g]), .rstN(rstN), .enAsync(activeEn[g]), .clkOut(clkOut[g])
    );
  end

  for (genvar p = 0; p < NPASS; p++) begin : gPass
    assign clkOut[NGATE+p] = clkIn[NGATE+p]; // R7
  end
endmodule

// File: tb/test_clkstop_top.sv
`timescale 1ns/1ps
module test_clkstop_top;
  logic        serClk = 1'b0;
  logic        serRun = 1'b1;
  logic        serData = 1'b1;
  logic        rstN = 1'b0;
  wire  [13:0] clkIn;
  wire  [13:0] clkOut;

  int nChecks = 0;
  int nErr = 0;

  always #5 serClk = serRun ? ~serClk : 1'b0;

  for (genvar g = 0; g < 14; g++) begin : gClk
    logic c = 1'b0;
    always #(3 + g) c = ~c;
    assign clkIn[g] = c;
  end

  clkstop_top i_clkstop_top (
    .serClk(serClk), .serData(serData), .rstN(rstN), .clkIn(clkIn), .clkOut(clkOut)
  );

  int      edgeCnt[14];
  realtime riseT[14];
  int      shortPulses = 0;
  logic [13:0] prevOut = '0;

  always @(clkOut) begin
    for (int i = 0; i < 14; i++) begin
      if (clkOut[i] && !prevOut[i]) begin
        edgeCnt[i]++;
        riseT[i] = $realtime;
      end else if (!clkOut[i] && prevOut[i]) begin
        if (rstN && ($realtime - riseT[i]) != real'(3 + i)) shortPulses++;
      end
    end
    prevOut = clkOut;
  end

  localparam logic [11:0] VEC [6] = '{12'h000, 12'hFFF, 12'hA5A, 12'h5A5, 12'h001, 12'h800};

  task automatic check(input string req, input logic [13:0] got, input logic [13:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic observe(output logic [13:0] running);
    int snap[14];
    for (int i = 0; i < 14; i++) snap[i] = edgeCnt[i];
    #300;
    for (int i = 0; i < 14; i++) running[i] = (edgeCnt[i] != snap[i]);
  endtask

  task automatic sendFrame(input logic [11:0] v, input bit endIdle);
    @(negedge serClk) serData = 1'b0;
    for (int k = 0; k < 12; k++) @(negedge serClk) serData = v[k];
    if (endIdle) @(negedge serClk) serData = 1'b1;
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    #2000000;
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [13:0] r;
    #53 rstN = 1'b1;
    #400;
    observe(r);
    check("R1 reset state all outputs run", r, 14'h3FFF);

    for (int i = 0; i < 6; i++) begin
      sendFrame(VEC[i], 1'b1);
      #400;
      observe(r);
      check("R3 R5 R7 vector", r, {2'b11, VEC[i]});
    end

    sendFrame(12'h000, 1'b1);
    #400;
    observe(r);
    check("R7 pass-through with all enables 0", {12'b0, r[13:12]}, 14'd3);

    sendFrame(12'h0F0, 1'b1);
    #400;
    serData = 1'b1;
    repeat (30) @(negedge serClk);
    observe(r);
    check("R2 idle ones ignored", r, {2'b11, 12'h0F0});

    begin
      logic [11:0] nv = 12'hF0F;
      @(negedge serClk) serData = 1'b0;
      for (int k = 0; k < 11; k++) @(negedge serClk) serData = nv[k];
      @(negedge serClk) begin serData = nv[11]; serRun = 1'b0; end
      #400;
      observe(r);
      check("R4 incomplete frame no effect", r, {2'b11, 12'h0F0});
      serRun = 1'b1;
      @(negedge serClk) serData = 1'b1;
      #400;
      observe(r);
      check("R4 frame completes on 12th bit", r, {2'b11, nv});
    end

    sendFrame(12'h3C3, 1'b0);
    sendFrame(12'hC3C, 1'b1);
    #400;
    observe(r);
    check("R8 back-to-back frames", r, {2'b11, 12'hC3C});

    for (int k = 0; k < 8; k++) begin
      sendFrame(12'hFFF, 1'b0);
      sendFrame(12'h000, 1'b0);
    end
    sendFrame(12'h6D9, 1'b1);
    #400;
    observe(r);
    check("R5 after rapid toggling", r, {2'b11, 12'h6D9});
    check("R6 no shortened pulse", 14'(shortPulses), 14'd0);

    finishRun();
  end
endmodule